// File: doc/BRIEF.md
# Addressed Serial Register Loader

This block is a three-wire serial write port that fills one of two 16-bit motor-control registers. Serial data is sampled on rising edges of a serial clock while chip select is high. Bits arrive least significant first and move into a holding register from the top, so the holding register always contains the most recent sixteen bits received. The upper four bits of the held word are an address. That address picks the control register which takes the word when it is latched.

A word is latched on a rising edge of the strobe input. When the strobe is left high, the port latches by itself each time a sixteenth bit has been counted since chip select last rose. A one-cycle write pulse marks every accepted latch. Words whose address matches neither register are dropped without any visible effect. All inputs are sampled by the system clock, and the serial clock is assumed to run several times slower than the system clock.

Top module: `serial_reg_loader`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both control registers read 16'h0000 and wr_pulse is 0.
- R2: The first bit shifted in becomes bit 0 of the word, and the sixteenth becomes bit 15.
- R3: When more than sixteen bits are shifted, only the last sixteen form the word.
- R4: Address bits [15:12] equal to 4'h0 load the whole word into motor_a_ctrl. Address 4'h1 loads it into motor_b_ctrl. The other register keeps its value.
- R5: A latch with an address of 4'h2 or higher changes neither register and raises no wr_pulse.
- R6: Serial clock edges seen while cs is low shift nothing.
- R7: Without a strobe rising edge and with the strobe low, no register changes even after sixteen bits.
- R8: With the strobe held high, the word is latched right after the sixteenth bit and again after every further sixteen, but never earlier.
- R9: A rising edge on cs clears the bit count, so bits shifted before it do not count toward the automatic latch.
- R10: Each accepted latch gives wr_pulse high for exactly one clock, in the same cycle the register takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data, least significant bit first |
| cs | input | 1 | Active-high chip select |
| strobe | input | 1 | Latch strobe; rising edge latches, held high means automatic latch |
| motor_a_ctrl | output | 16 | Control register for motor one (address 0) |
| motor_b_ctrl | output | 16 | Control register for motor two (address 1) |
| wr_pulse | output | 1 | One-cycle pulse on each accepted latch |

## Verification
On every cycle, the checker confirms that a low chip select freezes the holding register, and that the bit count wraps and clears on a chip-select rise. It also confirms that registers change only when a latch happens, that an address reaches only its own register, and that out-of-range addresses leave everything still. Bit order, overrun, the exact moment of the automatic latch, and the effect of stray bits before a chip-select rise depend on whole serial sequences. Only the bench's directed scenarios, which compare final register values and pulse counts against words built independently, can show those.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 2;
  localparam int CNT_W    = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // New bit enters at the top; the oldest bit falls off bit 0.
  function automatic word_t shift_lsb_first(input word_t cur, input logic din);
    return {din, cur[WORD_W-1:1]};
  endfunction

  function automatic addr_t word_addr(input word_t w);
    return w[WORD_W-1 -: ADDR_W];
  endfunction

  function automatic logic addr_in_range(input addr_t a);
    return (int'(a) < NUM_REGS);
  endfunction

  function automatic cnt_t count_next(input cnt_t c);
    return (int'(c) == WORD_W - 1) ? '0 : cnt_t'(c + 1'b1);
  endfunction
endpackage

// File: rtl/srl_edge_detect.sv
module srl_edge_detect #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= sig_in[i];
    end
    assign rise[i] = sig_in[i] & ~prev_q[i];
  end
endmodule

// File: rtl/srl_shift_stage.sv
module srl_shift_stage
  import srl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_rise,
  input  logic  cs_level,
  input  logic  cs_rise,
  input  logic  sdi,
  output word_t hold_q,
  output word_t hold_next,
  output cnt_t  bit_cnt,
  output logic  shift_evt,
  output logic  word_done
);
  cnt_t cnt_base;

  assign shift_evt = sclk_rise & cs_level;
  assign cnt_base  = cs_rise ? '0 : bit_cnt;
  assign word_done = shift_evt & (int'(cnt_base) == WORD_W - 1);
  assign hold_next = shift_evt ? shift_lsb_first(hold_q, sdi) : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      bit_cnt <= '0;
    end else begin
      hold_q  <= hold_next;
      bit_cnt <= shift_evt ? count_next(cnt_base) : cnt_base;
    end
  end
endmodule

// File: rtl/srl_reg_bank.sv
module srl_reg_bank
  import srl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       latch_en,
  input  word_t                      latch_word,
  output logic [NUM_REGS-1:0][WORD_W-1:0] regs_q,
  output logic                       wr_pulse
);
  addr_t               sel_addr;
  logic                sel_ok;
  logic [NUM_REGS-1:0] hit;

  assign sel_addr = word_addr(latch_word);
  assign sel_ok   = addr_in_range(sel_addr);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign hit[r] = latch_en & sel_ok & (int'(sel_addr) == r);
    always_ff @(posedge clk) begin
      if (!rst_n)      regs_q[r] <= '0;
      else if (hit[r]) regs_q[r] <= latch_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_pulse <= 1'b0;
    else        wr_pulse <= |hit;
  end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import srl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        cs,
  input  logic        strobe,
  output logic [15:0] motor_a_ctrl,
  output logic [15:0] motor_b_ctrl,
  output logic        wr_pulse
);
  localparam int EDGE_N = 3;

  logic [EDGE_N-1:0] edge_in, edge_rise;
  logic  sclk_rise, cs_rise, stb_rise;
  word_t hold_q, hold_next;
  cnt_t  bit_cnt;
  logic  shift_evt, word_done;
  logic  latch_en;
  word_t latch_word;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;

  assign edge_in = {strobe, cs, sclk};

  srl_edge_detect #(.N(EDGE_N)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_in(edge_in),
    .rise  (edge_rise)
  );

  assign sclk_rise = edge_rise[0];
  assign cs_rise   = edge_rise[1];
  assign stb_rise  = edge_rise[2];

  srl_shift_stage u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_rise(sclk_rise),
    .cs_level (cs),
    .cs_rise  (cs_rise),
    .sdi      (sdi),
    .hold_q   (hold_q),
    .hold_next(hold_next),
    .bit_cnt  (bit_cnt),
    .shift_evt(shift_evt),
    .word_done(word_done)
  );

  // Strobe edge latches; a strobe held high latches each completed word.
  assign latch_en   = stb_rise | (word_done & strobe);
  assign latch_word = hold_next;

  srl_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_en  (latch_en),
    .latch_word(latch_word),
    .regs_q    (regs_q),
    .wr_pulse  (wr_pulse)
  );

  assign motor_a_ctrl = regs_q[0];
  assign motor_b_ctrl = regs_q[1];
endmodule

// File: rtl/serial_reg_loader_chk.sv
module serial_reg_loader_chk
  import srl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        cs_rise,
  input logic        shift_evt,
  input cnt_t        bit_cnt,
  input word_t       hold_q,
  input logic        latch_en,
  input word_t       latch_word,
  input logic [15:0] motor_a_ctrl,
  input logic [15:0] motor_b_ctrl,
  input logic        wr_pulse
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (motor_a_ctrl == 16'h0 && motor_b_ctrl == 16'h0 && !wr_pulse));

  // R6
  cs_low_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(hold_q));

  // R9
  cs_rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !shift_evt) |=> (bit_cnt == '0));

  // R3
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !cs_rise && int'(bit_cnt) == WORD_W - 1) |=> (bit_cnt == '0));

  // R7
  no_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> ($stable(motor_a_ctrl) && $stable(motor_b_ctrl) && !wr_pulse));

  // R5
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && int'(latch_word[15:12]) >= NUM_REGS) |=>
      ($stable(motor_a_ctrl) && $stable(motor_b_ctrl) && !wr_pulse));

  // R4
  addr0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && latch_word[15:12] == 4'h0) |=>
      (motor_a_ctrl == $past(latch_word) && $stable(motor_b_ctrl)));

  // R4
  addr1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && latch_word[15:12] == 4'h1) |=>
      (motor_b_ctrl == $past(latch_word) && $stable(motor_a_ctrl)));

  // R10
  pulse_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && int'(latch_word[15:12]) < NUM_REGS) |=> wr_pulse);
endmodule

bind serial_reg_loader serial_reg_loader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs          (cs),
  .cs_rise     (cs_rise),
  .shift_evt   (shift_evt),
  .bit_cnt     (bit_cnt),
  .hold_q      (hold_q),
  .latch_en    (latch_en),
  .latch_word  (latch_word),
  .motor_a_ctrl(motor_a_ctrl),
  .motor_b_ctrl(motor_b_ctrl),
  .wr_pulse    (wr_pulse)
);

// File: tb/tb_serial_reg_loader.sv
`timescale 1ns/1ps
module tb_serial_reg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs = 1'b0, strobe = 1'b0;
  logic [15:0] motor_a_ctrl, motor_b_ctrl;
  logic wr_pulse;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  logic [15:0] exp_a = 16'h0, exp_b = 16'h0;

  always #5 clk = ~clk;

  serial_reg_loader dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs(cs), .strobe(strobe),
    .motor_a_ctrl(motor_a_ctrl), .motor_b_ctrl(motor_b_ctrl), .wr_pulse(wr_pulse)
  );

  always @(posedge clk) begin
    #2;
    if (wr_pulse) pulses++;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(motor_a_ctrl == exp_a, req, {16'h0, motor_a_ctrl}, {16'h0, exp_a});
    check(motor_b_ctrl == exp_b, req, {16'h0, motor_b_ctrl}, {16'h0, exp_b});
  endtask

  // Bits go out least significant first.
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdi = v[i]; sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
  endtask

  task automatic strobe_pulse(input logic expect_write, input string req);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk);
    check(wr_pulse == expect_write, req, {31'h0, wr_pulse}, {31'h0, expect_write});
    strobe = 1'b0;
    @(negedge clk);
    check(wr_pulse == 1'b0, "R10", {31'h0, wr_pulse}, 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_regs("R1");
    check(wr_pulse == 1'b0, "R1", {31'h0, wr_pulse}, 32'h0);
  endtask

  task automatic t_route_and_order();
    @(negedge clk); cs = 1'b1;
    send_bits(32'h0A5C, 16);
    @(negedge clk);
    check_regs("R7");
    strobe_pulse(1'b1, "R10");
    exp_a = 16'h0A5C;
    check_regs("R2");
    send_bits(32'h1F03, 16);
    strobe_pulse(1'b1, "R10");
    exp_b = 16'h1F03;
    check_regs("R4");
  endtask

  task automatic t_overrun();
    send_bits(32'h0F, 4);
    send_bits(32'h0123, 16);
    strobe_pulse(1'b1, "R10");
    exp_a = 16'h0123;
    check_regs("R3");
  endtask

  task automatic t_bad_addr();
    int p0;
    send_bits(32'h7777, 16);
    p0 = pulses;
    strobe_pulse(1'b0, "R5");
    check_regs("R5");
    check(pulses == p0, "R5", pulses, p0);
  endtask

  task automatic t_cs_low();
    send_bits(32'h1222, 16);
    @(negedge clk); cs = 1'b0;
    send_bits(32'h0BEE, 16);
    strobe_pulse(1'b1, "R10");
    exp_b = 16'h1222;
    check_regs("R6");
    @(negedge clk); cs = 1'b1;
  endtask

  task automatic t_tied_high();
    int p0;
    send_bits(32'hF000, 16);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk);
    check_regs("R8");
    p0 = pulses;
    send_bits(32'h0456, 15);
    check(pulses == p0, "R8", pulses, p0);
    check_regs("R8");
    send_bits(32'h0, 1);
    check(pulses == p0 + 1, "R8", pulses, p0 + 1);
    exp_a = 16'h0456;
    check_regs("R8");
    send_bits(32'h1789, 16);
    exp_b = 16'h1789;
    check_regs("R8");
    check(pulses == p0 + 2, "R8", pulses, p0 + 2);
  endtask

  task automatic t_count_clear();
    int p0;
    send_bits(32'h1F, 5);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); @(negedge clk); cs = 1'b1;
    @(negedge clk);
    p0 = pulses;
    send_bits(32'h0321, 11);
    check(pulses == p0, "R9", pulses, p0);
    send_bits(32'h0321 >> 11, 5);
    check(pulses == p0 + 1, "R9", pulses, p0 + 1);
    exp_a = 16'h0321;
    check_regs("R9");
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_a = 16'h0; exp_b = 16'h0;
    check_regs("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route_and_order();
    t_overrun();
    t_bad_addr();
    t_cs_low();
    t_tied_high();
    t_count_clear();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule